// File: doc/BRIEF.md
# SD Card Data Word FIFO

This block is the word buffer between the processor or DMA side of an SD host and the card-side data path. It holds up to sixteen 32-bit words. The processor reaches it through one data register: a read strobe pops a word and a write strobe pushes one. The card side is a plain word stream with a valid/ready handshake. It feeds the buffer when a block is coming from the card and drains it when a block is going to the card. The direction comes from the read and write bits of the command that is running.

The current fill level, together with two 5-bit thresholds, is shown in one debug word. The thresholds decide when the DMA request is raised. A processor access that would underflow or overflow the buffer leaves its contents alone and sets a sticky error flag. That flag is the FIFO-error bit of the host status word. Reset empties the buffer, and so does the start of every new data command.

Top module: `sd_word_fifo`

## Requirements
- R1: The buffer keeps up to 16 words of 32 bits in first-in first-out order. Its level counts from 0 to 16 and goes up by one on an accepted push and down by one on an accepted pop.
- R2: `dbg_word` shows the level in bits 8:4, the write threshold in bits 13:9 and the read threshold in bits 18:14. All of its other bits read zero.
- R3: In idle mode or card-to-host mode, a processor read of a non-empty buffer pops the oldest word. That word appears on `cpu_rdata` in the same cycle as the strobe.
- R4: In idle mode or host-to-card mode, a processor write to a buffer that is not full pushes `cpu_wdata`. The new level is visible in the next cycle.
- R5: In card-to-host mode, `card_in_ready` is high while level < 16, and a word is pushed when valid and ready are both high. In host-to-card mode, `card_out_valid` is high while level > 0, with the oldest word on `card_out_data`, and a word is popped when valid and ready are both high. In any other mode both strobes are low.
- R6: A processor pop of an empty buffer returns zero and changes nothing. A processor push to a full buffer is dropped. Either one sets `fifo_err` in the next cycle. The flag stays set until an `err_clr` cycle, and a set in the same cycle as a clear wins.
- R7: `dma_req` is high in card-to-host mode while level > read threshold. It is high in host-to-card mode while (16 - level) > write threshold. It is always low in idle mode.
- R8: The mode is card-to-host when `cmd_rd_bit` is 1, regardless of `cmd_wr_bit`. It is host-to-card when only `cmd_wr_bit` is 1, and idle when both bits are 0. Reset empties the buffer. A `cmd_start` cycle also empties it (level 0 in the next cycle): every access in that cycle is ignored, no error is flagged, and both card strobes are low.
- R9: A processor access against the transfer direction is ignored. A write in card-to-host mode changes nothing. A read in host-to-card mode returns zero and does not pop. Neither one sets `fifo_err`.
- R10: The level before the edge decides whether a push or a pop is accepted. A push and a pop accepted together leave the level unchanged. A push to a full buffer is still dropped when a pop is accepted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Pulse at the start of a new data command; empties the buffer |
| cmd_rd_bit | input | 1 | Read bit of the active command (card to host) |
| cmd_wr_bit | input | 1 | Write bit of the active command (host to card) |
| rd_thresh | input | 5 | Read threshold for the DMA request |
| wr_thresh | input | 5 | Write threshold for the DMA request |
| cpu_rd | input | 1 | Data register read strobe (pop) |
| cpu_wr | input | 1 | Data register write strobe (push) |
| cpu_wdata | input | 32 | Data register write word |
| cpu_rdata | output | 32 | Word popped by the read strobe, zero otherwise |
| card_in_valid | input | 1 | Card stream offers a word (card-to-host) |
| card_in_data | input | 32 | Word from the card stream |
| card_in_ready | output | 1 | Buffer accepts a card word |
| card_out_valid | output | 1 | Buffer offers a word to the card stream (host-to-card) |
| card_out_data | output | 32 | Oldest word, going to the card stream |
| card_out_ready | input | 1 | Card stream takes the offered word |
| err_clr | input | 1 | Clears the FIFO error flag |
| fifo_err | output | 1 | Sticky FIFO error flag (host status bit 3) |
| dma_req | output | 1 | DMA request |
| dbg_word | output | 32 | Debug word: level and both thresholds |

## Verification
The bench first fills the buffer to 16 and pushes once more, then drains it to 0 and pops once more. A design with an off-by-one full or empty test would store a seventeenth word, would wrap the level, or would never raise the error flag. It also pushes at full while popping in the same cycle. A design that judged acceptance on the level after the pop would take that word, so the level would stay at 16 instead of dropping to 15. It issues processor accesses against the transfer direction and accesses in the same cycle as a command start. A design that let these through would move the level or raise a false error. It sets thresholds at the level boundaries, where a comparison using >= instead of > shows up as a DMA request raised one level early.

// File: rtl/sdfifo_pkg.sv
package sdfifo_pkg;

    typedef enum logic [1:0] {
        XFER_IDLE         = 2'd0,
        XFER_CARD_TO_HOST = 2'd1,
        XFER_HOST_TO_CARD = 2'd2
    } xfer_mode_e;

    typedef struct packed {
        logic push;       // accepted push this cycle
        logic pop;        // accepted pop this cycle
        logic from_card;  // push word comes from the card stream
        logic cpu_pop;    // accepted pop belongs to the processor
        logic err_set;    // processor underflow or overflow
    } access_t;

    // R8: the read bit wins when both direction bits are set
    function automatic xfer_mode_e decode_mode(input logic rd_bit, input logic wr_bit);
        if (rd_bit)      return XFER_CARD_TO_HOST;
        else if (wr_bit) return XFER_HOST_TO_CARD;
        else             return XFER_IDLE;
    endfunction

endpackage

// File: rtl/sdf_route.sv
module sdf_route
    import sdfifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  xfer_mode_e       mode,
    input  logic             flush,
    input  logic             cpu_rd,
    input  logic             cpu_wr,
    input  logic             card_in_valid,
    input  logic             card_out_ready,
    input  logic [LVL_W-1:0] level,
    output access_t          acc,
    output logic             card_in_ready,
    output logic             card_out_valid
);

    logic full, empty;
    logic cpu_pop_req, cpu_push_req, card_push_req, card_pop_req;

    always_comb begin
        full          = (level == LVL_W'(DEPTH));
        empty         = (level == '0);
        // R9: processor accesses against the direction are not requests
        cpu_pop_req   = cpu_rd && (mode != XFER_HOST_TO_CARD);
        cpu_push_req  = cpu_wr && (mode != XFER_CARD_TO_HOST);
        card_push_req = card_in_valid  && (mode == XFER_CARD_TO_HOST);
        card_pop_req  = card_out_ready && (mode == XFER_HOST_TO_CARD);

        // R10: acceptance judged on the level before the edge
        acc.push      = !flush && (cpu_push_req || card_push_req) && !full;
        acc.pop       = !flush && (cpu_pop_req  || card_pop_req)  && !empty;
        acc.from_card = (mode == XFER_CARD_TO_HOST);
        acc.cpu_pop   = !flush && cpu_pop_req && !empty;
        acc.err_set   = !flush && ((cpu_pop_req && empty) || (cpu_push_req && full));

        card_in_ready  = !flush && (mode == XFER_CARD_TO_HOST) && !full;
        card_out_valid = !flush && (mode == XFER_HOST_TO_CARD) && !empty;
    end

endmodule

// File: rtl/sdf_store.sv
module sdf_store #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 16,
    parameter int PTR_W  = $clog2(DEPTH),
    parameter int LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic              pop,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] head,
    output logic [LVL_W-1:0]  level
);

    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [LVL_W-1:0] lvl;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic [WORD_W-1:0] mem_q [DEPTH];

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        ctl_d = ctl_q;
        if (flush) begin
            ctl_d = '0;
        end else begin
            if (push) ctl_d.wp = ptr_next(ctl_q.wp);
            if (pop)  ctl_d.rp = ptr_next(ctl_q.rp);
            case ({push, pop})
                2'b10:   ctl_d.lvl = ctl_q.lvl + 1'b1;
                2'b01:   ctl_d.lvl = ctl_q.lvl - 1'b1;
                default: ctl_d.lvl = ctl_q.lvl;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_ff @(posedge clk) begin
        if (push && !flush) mem_q[ctl_q.wp] <= wdata;
    end

    assign head  = mem_q[ctl_q.rp];
    assign level = ctl_q.lvl;

    // R6: the router never passes a pop of an empty store or a push to a full one
    assert_pop_nonempty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (ctl_q.lvl != '0));
    assert_push_notfull_R6: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (ctl_q.lvl != LVL_W'(DEPTH)));
    // R8: a flush leaves the store empty
    assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (level == '0));
    // R10: a push and a pop together keep the level
    assert_level_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !flush) |=> $stable(level));

endmodule

// File: rtl/sdf_err_flag.sv
module sdf_err_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic err
);

    logic err_d, err_q;

    always_comb begin
        err_d = err_q;
        if (set)      err_d = 1'b1;
        else if (clr) err_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= err_d;
    end

    assign err = err_q;

    // R6: the flag is sticky until cleared, and a set always lands
    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !clr) |=> err);
    assert_err_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> err);

endmodule

// File: rtl/sdf_dma_req.sv
module sdf_dma_req
    import sdfifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LVL_W = $clog2(DEPTH + 1),
    parameter int TH_W  = 5
) (
    input  xfer_mode_e       mode,
    input  logic [LVL_W-1:0] level,
    input  logic [TH_W-1:0]  rd_thresh,
    input  logic [TH_W-1:0]  wr_thresh,
    output logic             req
);

    localparam int CW = ((LVL_W > TH_W) ? LVL_W : TH_W) + 1;

    logic [CW-1:0] lvl_x, free_x, rth_x, wth_x;

    always_comb begin
        lvl_x  = CW'(level);
        free_x = CW'(DEPTH) - lvl_x;
        rth_x  = CW'(rd_thresh);
        wth_x  = CW'(wr_thresh);
        case (mode)
            XFER_CARD_TO_HOST: req = (lvl_x > rth_x);
            XFER_HOST_TO_CARD: req = (free_x > wth_x);
            default:           req = 1'b0;
        endcase
    end

endmodule

// File: rtl/sd_word_fifo.sv
module sd_word_fifo
    import sdfifo_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 16,
    parameter int TH_W   = 5,
    parameter int DBG_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic              cmd_rd_bit,
    input  logic              cmd_wr_bit,
    input  logic [TH_W-1:0]   rd_thresh,
    input  logic [TH_W-1:0]   wr_thresh,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [WORD_W-1:0] cpu_wdata,
    output logic [WORD_W-1:0] cpu_rdata,
    input  logic              card_in_valid,
    input  logic [WORD_W-1:0] card_in_data,
    output logic              card_in_ready,
    output logic              card_out_valid,
    output logic [WORD_W-1:0] card_out_data,
    input  logic              card_out_ready,
    input  logic              err_clr,
    output logic              fifo_err,
    output logic              dma_req,
    output logic [DBG_W-1:0]  dbg_word
);

    localparam int LVL_W   = $clog2(DEPTH + 1);
    // debug word field positions (R2)
    localparam int LVL_LSB = 4;
    localparam int WTH_LSB = 9;
    localparam int RTH_LSB = 14;

    xfer_mode_e        mode;
    access_t           acc;
    logic [LVL_W-1:0]  level;
    logic [WORD_W-1:0] head;
    logic [WORD_W-1:0] push_word;

    assign mode      = decode_mode(cmd_rd_bit, cmd_wr_bit);
    assign push_word = acc.from_card ? card_in_data : cpu_wdata;

    sdf_route #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_route (
        .mode           (mode),
        .flush          (cmd_start),
        .cpu_rd         (cpu_rd),
        .cpu_wr         (cpu_wr),
        .card_in_valid  (card_in_valid),
        .card_out_ready (card_out_ready),
        .level          (level),
        .acc            (acc),
        .card_in_ready  (card_in_ready),
        .card_out_valid (card_out_valid)
    );

    sdf_store #(.WORD_W(WORD_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (cmd_start),
        .push  (acc.push),
        .pop   (acc.pop),
        .wdata (push_word),
        .head  (head),
        .level (level)
    );

    sdf_err_flag u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (acc.err_set),
        .clr   (err_clr),
        .err   (fifo_err)
    );

    sdf_dma_req #(.DEPTH(DEPTH), .LVL_W(LVL_W), .TH_W(TH_W)) u_dma (
        .mode      (mode),
        .level     (level),
        .rd_thresh (rd_thresh),
        .wr_thresh (wr_thresh),
        .req       (dma_req)
    );

    assign cpu_rdata     = acc.cpu_pop ? head : '0;
    assign card_out_data = head;

    always_comb begin
        dbg_word = '0;
        dbg_word[LVL_LSB +: LVL_W] = level;
        dbg_word[WTH_LSB +: TH_W]  = wr_thresh;
        dbg_word[RTH_LSB +: TH_W]  = rd_thresh;
    end

    // R7: no DMA request without a transfer direction
    assert_dma_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == XFER_IDLE) |-> !dma_req);
    // R5: the card stream never pushes and pops in the same cycle
    assert_one_card_side_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(card_in_ready && card_out_valid));
    // R6: a processor pop of an empty buffer raises the error flag
    assert_underflow_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !cmd_start && (mode != XFER_HOST_TO_CARD) && (level == '0)) |=> fifo_err);
    // R9: a read against the direction never returns data
    assert_wrong_dir_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == XFER_HOST_TO_CARD) |-> (cpu_rdata == '0));

endmodule

// File: tb/sim_sd_word_fifo.sv
`timescale 1ns/1ps
module sim_sd_word_fifo;

    localparam int D = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start = 0, cmd_rd_bit = 0, cmd_wr_bit = 0;
    logic [4:0]  rd_thresh = 0, wr_thresh = 0;
    logic        cpu_rd = 0, cpu_wr = 0;
    logic [31:0] cpu_wdata = 0, cpu_rdata;
    logic        card_in_valid = 0, card_in_ready;
    logic [31:0] card_in_data = 0, card_out_data;
    logic        card_out_valid, card_out_ready = 0;
    logic        err_clr = 0, fifo_err, dma_req;
    logic [31:0] dbg_word;

    always #4 clk = ~clk;

    sd_word_fifo u0 (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_rd_bit(cmd_rd_bit),
        .cmd_wr_bit(cmd_wr_bit), .rd_thresh(rd_thresh), .wr_thresh(wr_thresh),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .card_in_valid(card_in_valid), .card_in_data(card_in_data),
        .card_in_ready(card_in_ready), .card_out_valid(card_out_valid),
        .card_out_data(card_out_data), .card_out_ready(card_out_ready),
        .err_clr(err_clr), .fifo_err(fifo_err), .dma_req(dma_req), .dbg_word(dbg_word)
    );

    int          n_chk = 0;
    int          n_fail = 0;
    logic [31:0] q[$];
    logic        m_err = 1'b0;
    string       lvl_tag = "R1";

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // expected outputs from the model state and the current inputs
    task automatic compare();
        logic rdm, wrm;
        int lvl;
        logic [31:0] head, exp_rd;
        logic exp_dma;
        rdm  = cmd_rd_bit;
        wrm  = cmd_wr_bit && !cmd_rd_bit;
        lvl  = q.size();
        head = (lvl > 0) ? q[0] : 32'h0;
        exp_rd = (!cmd_start && cpu_rd && !wrm && lvl > 0) ? head : 32'h0;
        chk((cpu_rd && wrm) ? "R9 cpu_rdata" : "R3 cpu_rdata", cpu_rdata, exp_rd);
        chk("R5 card_in_ready", {31'b0, card_in_ready}, {31'b0, rdm && lvl < D && !cmd_start});
        chk("R5 card_out_valid", {31'b0, card_out_valid}, {31'b0, wrm && lvl > 0 && !cmd_start});
        if (wrm && lvl > 0) chk("R5 card_out_data", card_out_data, head);
        if (rdm)      exp_dma = (lvl > int'(rd_thresh));
        else if (wrm) exp_dma = ((D - lvl) > int'(wr_thresh));
        else          exp_dma = 1'b0;
        chk("R7 dma_req", {31'b0, dma_req}, {31'b0, exp_dma});
        chk({lvl_tag, " level"}, {27'b0, dbg_word[8:4]}, 32'(lvl));
        chk("R2 debug word", dbg_word, {13'b0, rd_thresh, wr_thresh, 5'(lvl), 4'b0});
        chk("R6 fifo_err", {31'b0, fifo_err}, {31'b0, m_err});
    endtask

    task automatic model_update();
        logic rdm, wrm, cpu_pop_req, cpu_push_req, card_push, card_pop, err_set;
        int lvl;
        rdm = cmd_rd_bit;
        wrm = cmd_wr_bit && !cmd_rd_bit;
        lvl = q.size();
        if (!rst_n) begin
            q.delete(); m_err = 1'b0; lvl_tag = "R8"; return;
        end
        cpu_pop_req  = cpu_rd && !wrm;
        cpu_push_req = cpu_wr && !rdm;
        card_push    = rdm && card_in_valid;
        card_pop     = wrm && card_out_ready;
        err_set      = 1'b0;
        if (cmd_start) begin
            q.delete();
            lvl_tag = "R8";
        end else begin
            if ((cpu_wr && rdm) || (cpu_rd && wrm))               lvl_tag = "R9";
            else if ((cpu_pop_req || card_pop) && (cpu_push_req || card_push)) lvl_tag = "R10";
            else if (cpu_push_req)                                lvl_tag = "R4";
            else                                                  lvl_tag = "R1";
            err_set = (cpu_pop_req && lvl == 0) || (cpu_push_req && lvl == D);
            if ((cpu_pop_req || card_pop) && lvl > 0) void'(q.pop_front());
            if ((cpu_push_req || card_push) && lvl < D)
                q.push_back(rdm ? card_in_data : cpu_wdata);
        end
        if (err_set)      m_err = 1'b1;
        else if (err_clr) m_err = 1'b0;
    endtask

    task automatic step();
        #1 compare();
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic quiet();
        cmd_start = 0; cpu_rd = 0; cpu_wr = 0; card_in_valid = 0;
        card_out_ready = 0; err_clr = 0;
    endtask

    task automatic new_cmd(input logic rd_b, input logic wr_b);
        quiet();
        cmd_rd_bit = rd_b; cmd_wr_bit = wr_b; cmd_start = 1;
        step();
        cmd_start = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        // reset state (R8)
        for (int i = 0; i < 3; i++) step();
        chk("R8 reset level", {27'b0, dbg_word[8:4]}, 32'h0);
        chk("R8 reset err", {31'b0, fifo_err}, 32'h0);
        rst_n = 1'b1;

        // idle mode: fill past full (R4, R6), clear, drain past empty (R3, R6)
        rd_thresh = 5'd3; wr_thresh = 5'd5;
        quiet();
        for (int i = 0; i < D + 1; i++) begin
            cpu_wr = 1; cpu_wdata = 32'hA000_0000 + 32'(i); step();
        end
        quiet(); step();
        chk("R6 overflow flag", {31'b0, fifo_err}, 32'h1);
        err_clr = 1; step(); quiet(); step();
        for (int i = 0; i < D + 1; i++) begin
            cpu_rd = 1; step();
        end
        quiet(); step();
        chk("R6 underflow flag", {31'b0, fifo_err}, 32'h1);
        err_clr = 1; cpu_rd = 1; step(); // set wins over clear
        quiet(); step();

        // card-to-host: card fills, processor writes ignored (R9)
        new_cmd(1'b1, 1'b0);
        rd_thresh = 5'd15;
        for (int i = 0; i < D + 2; i++) begin
            card_in_valid = 1; card_in_data = 32'hC000_0000 + 32'(i);
            cpu_wr = 1; cpu_wdata = 32'hDEAD_0000;
            step();
        end
        quiet(); rd_thresh = 5'd16; step();
        // drain with simultaneous card pushes (R10)
        for (int i = 0; i < 10; i++) begin
            cpu_rd = 1; card_in_valid = 1; card_in_data = 32'hC100_0000 + 32'(i); step();
        end
        quiet();
        // flush with accesses in the same cycle (R8)
        cmd_start = 1; cpu_rd = 1; card_in_valid = 1; step();
        quiet(); step();

        // host-to-card: processor fills, reads ignored (R9)
        new_cmd(1'b0, 1'b1);
        wr_thresh = 5'd0;
        for (int i = 0; i < D; i++) begin
            cpu_wr = 1; cpu_wdata = 32'hB000_0000 + 32'(i); cpu_rd = (i % 3 == 0); step();
        end
        quiet();
        // push at full with card pop in the same cycle (R10)
        cpu_wr = 1; cpu_wdata = 32'hEEEE_EEEE; card_out_ready = 1; step();
        quiet(); err_clr = 1; step(); quiet();
        for (int i = 0; i < D + 1; i++) begin
            card_out_ready = 1; step();
        end
        quiet(); step();

        // both direction bits set: card-to-host wins (R8)
        new_cmd(1'b1, 1'b1);
        card_in_valid = 1; card_in_data = 32'h1234_5678; cpu_wr = 1; step();
        quiet(); step();

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            quiet();
            if ($urandom_range(0, 63) == 0) begin
                cmd_rd_bit = 1'($urandom_range(0, 1));
                cmd_wr_bit = 1'($urandom_range(0, 1));
                cmd_start  = 1;
            end
            if ($urandom_range(0, 31) == 0) begin
                rd_thresh = 5'($urandom_range(0, 16));
                wr_thresh = 5'($urandom_range(0, 16));
            end
            cpu_rd         = ($urandom_range(0, 3) == 0);
            cpu_wr         = ($urandom_range(0, 3) == 0);
            cpu_wdata      = $urandom;
            card_in_valid  = ($urandom_range(0, 1) == 0);
            card_in_data   = $urandom;
            card_out_ready = ($urandom_range(0, 1) == 0);
            err_clr        = ($urandom_range(0, 15) == 0);
            step();
        end
        quiet(); step();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule